// File: doc/BRIEF.md
# ACPI PM1 Event Register Bank

This block holds the fixed ACPI PM1 event state that a host and an embedded controller (EC) share: status flags for the power button, the sleep button, the RTC alarm, the power-button override and wake, the matching enable flags, and a control register that carries a sleep type and a sleep-enable trigger. Each side has its own plain synchronous register port. A write takes effect on the clock edge where the write strobe is sampled. Read data is combinational from the selected address.

The host can only clear status flags, by writing ones. It owns the enable and control registers. The EC owns the status flags outright: it can set or clear them. The block drives an active-low SCI line to the host whenever an enabled event is pending. It also gives the EC three one-cycle notifications: the host wrote the enable register, the host wrote the status register, or the host requested sleep. A quiesce input from the clock and reset controller silences those notifications. Register state and the SCI line keep working while the input is high.

Register selects on both ports are: 0 status, 1 enable, 2 control, 3 override control.

Top module: `pm1_evt_bank`

## Requirements
- R1: While and right after reset, every register reads 0x00 on both ports, `sci_n` is 1 and all three EC pulse outputs are 0.
- R2: Unimplemented bit positions always read 0 on both ports. The readable masks are: status 0x8F (bit 0 power button, bit 1 sleep button, bit 2 RTC alarm, bit 3 override, bit 7 wake), enable 0x07 (same positions as status bits 0 to 2), control 0x1C, override control 0x02.
- R3: An EC write to select 0 loads the implemented status bits with the written value, so the EC can set bits to 1 and clear them to 0.
- R4: A host write to select 0 clears each status bit written as 1. Bits written as 0 keep their value.
- R5: When an EC status write and a host status write land in the same cycle, the EC value is what the status register holds afterwards. An EC set beats a host clear.
- R6: The enable, control and override control registers change only on host writes. EC writes to selects 1, 2 and 3 change nothing.
- R7: `sci_n` is 0 exactly when one of these is true: a status bit in positions 0 to 2 is set together with the enable bit in the same position, or status bit 3 is set together with override control bit 1. Wake status (bit 7) never drives SCI.
- R8: A host write to select 1 makes `ec_en_irq` high for exactly the one cycle after the write edge. A host write to select 0 does the same for `ec_sts_irq`.
- R9: Control bits [4:2] store the sleep type. Bit 5 (sleep enable) always reads 0. A host write to select 2 with bit 5 set makes `ec_slp_req` high for the one cycle after the write edge.
- R10: While `quiesce` is high in the write cycle, no EC pulse is produced. Register writes and `sci_n` still behave normally, and pulses return once `quiesce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quiesce | input | 1 | Low-power request; silences EC pulses |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| ec_we | input | 1 | EC write strobe |
| ec_addr | input | 2 | EC register select |
| ec_wdata | input | 8 | EC write data |
| ec_rdata | output | 8 | EC read data for `ec_addr` |
| sci_n | output | 1 | Active-low SCI to host |
| ec_en_irq | output | 1 | Pulse: host wrote enable register |
| ec_sts_irq | output | 1 | Pulse: host wrote status register |
| ec_slp_req | output | 1 | Pulse: host set sleep enable |

## Verification
The assertions assume that write strobes, selects and data are stable around the sampling edge. They also assume that a strobe held high for several cycles counts as one write per cycle. The bench drives every input on the falling edge and raises each strobe for exactly one cycle, so every write maps to one rising edge. It does the same for the one deliberately simultaneous host-and-EC status write. The override control and enable values are swept in outer loops, and all 256 status values are written by the EC in an inner loop. This covers every combination that can reach the SCI line.

// File: rtl/pm1_evt_pkg.sv
package pm1_evt_pkg;

    localparam int DW = 8;
    localparam int AW = 2;

    // status / enable bit positions
    localparam int B_PWR = 0;
    localparam int B_SLP = 1;
    localparam int B_RTC = 2;
    localparam int B_OVR = 3;
    localparam int B_WAK = 7;

    // control register fields
    localparam int TYP_LO  = 2;
    localparam int TYP_W   = 3;
    localparam int SLPEN_B = 5;
    // override control
    localparam int OVREN_B = 1;

    localparam int NPULSE = 3;
    localparam int P_EN   = 0;
    localparam int P_STS  = 1;
    localparam int P_SLP  = 2;

    localparam logic [DW-1:0] STS_MASK  = DW'((1 << B_PWR) | (1 << B_SLP) | (1 << B_RTC)
                                              | (1 << B_OVR) | (1 << B_WAK));
    localparam logic [DW-1:0] EN_MASK   = DW'((1 << B_PWR) | (1 << B_SLP) | (1 << B_RTC));
    localparam logic [DW-1:0] CTL_MASK  = DW'(((1 << TYP_W) - 1) << TYP_LO);
    localparam logic [DW-1:0] OCTL_MASK = DW'(1 << OVREN_B);

    typedef enum logic [AW-1:0] {
        SEL_STS  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_OCTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            we;
        reg_sel_e        sel;
        logic [DW-1:0]   data;
    } wr_req_t;

    typedef struct packed {
        logic [DW-1:0] sts;
        logic [DW-1:0] en;
        logic [DW-1:0] ctl;
        logic [DW-1:0] octl;
    } bank_t;

    // EC load has priority over host clear, so an EC set is never lost
    function automatic logic [DW-1:0] sts_next(input logic [DW-1:0] cur,
                                               input logic ec_ld,
                                               input logic [DW-1:0] ec_val,
                                               input logic [DW-1:0] host_clr);
        return ec_ld ? ec_val : (cur & ~host_clr);
    endfunction

    function automatic logic event_pending(input bank_t b);
        return (|(b.sts & b.en & EN_MASK)) || (b.sts[B_OVR] && b.octl[OVREN_B]);
    endfunction

    function automatic logic [DW-1:0] read_sel(input reg_sel_e sel, input bank_t b);
        case (sel)
            SEL_STS:  return b.sts;
            SEL_EN:   return b.en;
            SEL_CTL:  return b.ctl;
            default:  return b.octl;
        endcase
    endfunction

endpackage

// File: rtl/pm1_sts_reg.sv
module pm1_sts_reg
    import pm1_evt_pkg::*;
#(
    parameter logic [DW-1:0] MASK = STS_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ec_ld,
    input  logic [DW-1:0] ec_val,
    input  logic [DW-1:0] host_clr,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= sts_next(q, ec_ld, ec_val, host_clr) & MASK;
    end
endmodule

// File: rtl/pm1_host_reg.sv
module pm1_host_reg
    import pm1_evt_pkg::*;
#(
    parameter logic [DW-1:0] MASK = EN_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata & MASK;
    end
endmodule

// File: rtl/pm1_pulse_gen.sv
module pm1_pulse_gen
    import pm1_evt_pkg::*;
#(
    parameter int N = NPULSE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         quiet,
    input  logic [N-1:0] req,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (rst) pulse[i] <= 1'b0;
            else     pulse[i] <= req[i] && !quiet;
        end
    end
endmodule

// File: rtl/pm1_evt_bank.sv
module pm1_evt_bank
    import pm1_evt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          quiesce,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          ec_we,
    input  logic [AW-1:0] ec_addr,
    input  logic [DW-1:0] ec_wdata,
    output logic [DW-1:0] ec_rdata,
    output logic          sci_n,
    output logic          ec_en_irq,
    output logic          ec_sts_irq,
    output logic          ec_slp_req
);
    wr_req_t h_req, e_req;
    bank_t   bank;
    logic [DW-1:0] sts_q, en_q, ctl_q, octl_q;
    logic h_sts, h_en, h_ctl, h_octl, e_sts;
    logic [NPULSE-1:0] p_req, p_out;

    assign h_req = '{we: host_we, sel: reg_sel_e'(host_addr), data: host_wdata};
    assign e_req = '{we: ec_we,   sel: reg_sel_e'(ec_addr),   data: ec_wdata};

    assign h_sts  = h_req.we && (h_req.sel == SEL_STS);
    assign h_en   = h_req.we && (h_req.sel == SEL_EN);
    assign h_ctl  = h_req.we && (h_req.sel == SEL_CTL);
    assign h_octl = h_req.we && (h_req.sel == SEL_OCTL);
    assign e_sts  = e_req.we && (e_req.sel == SEL_STS);

    pm1_sts_reg #(.MASK(STS_MASK)) u_sts (
        .clk(clk), .rst(rst),
        .ec_ld(e_sts), .ec_val(e_req.data),
        .host_clr(h_sts ? h_req.data : '0),
        .q(sts_q)
    );

    pm1_host_reg #(.MASK(EN_MASK)) u_en (
        .clk(clk), .rst(rst), .wr(h_en), .wdata(h_req.data), .q(en_q)
    );

    // sleep enable is not stored: only the type field survives the mask
    pm1_host_reg #(.MASK(CTL_MASK)) u_ctl (
        .clk(clk), .rst(rst), .wr(h_ctl), .wdata(h_req.data), .q(ctl_q)
    );

    pm1_host_reg #(.MASK(OCTL_MASK)) u_octl (
        .clk(clk), .rst(rst), .wr(h_octl), .wdata(h_req.data), .q(octl_q)
    );

    always_comb begin
        p_req         = '0;
        p_req[P_EN]   = h_en;
        p_req[P_STS]  = h_sts;
        p_req[P_SLP]  = h_ctl && h_req.data[SLPEN_B];
    end

    pm1_pulse_gen #(.N(NPULSE)) u_pulse (
        .clk(clk), .rst(rst), .quiet(quiesce), .req(p_req), .pulse(p_out)
    );

    assign bank       = '{sts: sts_q, en: en_q, ctl: ctl_q, octl: octl_q};
    assign host_rdata = read_sel(h_req.sel, bank);
    assign ec_rdata   = read_sel(e_req.sel, bank);
    assign sci_n      = !event_pending(bank);

    assign ec_en_irq  = p_out[P_EN];
    assign ec_sts_irq = p_out[P_STS];
    assign ec_slp_req = p_out[P_SLP];
endmodule

// File: rtl/pm1_evt_bank_chk.sv
module pm1_evt_bank_chk
    import pm1_evt_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          quiesce,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] host_wdata,
    input logic          ec_we,
    input logic [AW-1:0] ec_addr,
    input logic [DW-1:0] ec_wdata,
    input logic [DW-1:0] sts_q,
    input logic [DW-1:0] en_q,
    input logic          sci_n,
    input logic          ec_en_irq,
    input logic          ec_sts_irq,
    input logic          ec_slp_req
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (sts_q == '0) && sci_n && !ec_en_irq && !ec_sts_irq && !ec_slp_req);

    p_ec_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ec_we && ec_addr == 2'd0) |=> sts_q == ($past(ec_wdata) & STS_MASK));

    p_host_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd0 && !(ec_we && ec_addr == 2'd0))
        |=> sts_q == ($past(sts_q) & ~$past(host_wdata)));

    // R5: EC set survives a same-cycle host clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (ec_we && ec_addr == 2'd0 && host_we && host_addr == 2'd0)
        |=> (sts_q & $past(ec_wdata) & STS_MASK) == ($past(ec_wdata) & STS_MASK));

    p_en_host_only_r6: assert property (@(posedge clk) disable iff (rst)
        !(host_we && host_addr == 2'd1) |=> $stable(en_q));

    p_en_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd1 && !quiesce) |=> ec_en_irq);

    p_sts_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd0 && !quiesce) |=> ec_sts_irq);

    p_slp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd2 && host_wdata[SLPEN_B] && !quiesce) |=> ec_slp_req);

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        quiesce |=> !ec_en_irq && !ec_sts_irq && !ec_slp_req);

    p_wake_no_sci_r7: assert property (@(posedge clk) disable iff (rst)
        ((sts_q & ~(DW'(1) << B_WAK)) == '0) |-> sci_n);
endmodule

bind pm1_evt_bank pm1_evt_bank_chk u_chk (
    .clk(clk), .rst(rst), .quiesce(quiesce),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .ec_we(ec_we), .ec_addr(ec_addr), .ec_wdata(ec_wdata),
    .sts_q(sts_q), .en_q(en_q), .sci_n(sci_n),
    .ec_en_irq(ec_en_irq), .ec_sts_irq(ec_sts_irq), .ec_slp_req(ec_slp_req)
);

// File: tb/test_pm1_evt_bank.sv
`timescale 1ns/1ps
module test_pm1_evt_bank;
    logic clk = 0, rst = 1, quiesce = 0;
    logic host_we = 0, ec_we = 0;
    logic [1:0] host_addr = 0, ec_addr = 0;
    logic [7:0] host_wdata = 0, ec_wdata = 0;
    logic [7:0] host_rdata, ec_rdata;
    logic sci_n, ec_en_irq, ec_sts_irq, ec_slp_req;
    int total = 0, bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    pm1_evt_bank i_pm1_evt_bank (
        .clk(clk), .rst(rst), .quiesce(quiesce),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ec_we(ec_we), .ec_addr(ec_addr), .ec_wdata(ec_wdata), .ec_rdata(ec_rdata),
        .sci_n(sci_n), .ec_en_irq(ec_en_irq), .ec_sts_irq(ec_sts_irq),
        .ec_slp_req(ec_slp_req)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_we = 0;
    endtask

    task automatic ec_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); ec_we = 1; ec_addr = a; ec_wdata = d;
        @(negedge clk); ec_we = 0;
    endtask

    task automatic both_sts(input logic [7:0] ecd, input logic [7:0] hd);
        @(negedge clk);
        ec_we = 1; ec_addr = 0; ec_wdata = ecd;
        host_we = 1; host_addr = 0; host_wdata = hd;
        @(negedge clk); ec_we = 0; host_we = 0;
    endtask

    task automatic rd_h(input logic [1:0] a, output logic [7:0] d);
        host_addr = a; #0.5; d = host_rdata;
    endtask

    task automatic rd_e(input logic [1:0] a, output logic [7:0] d);
        ec_addr = a; #0.5; d = ec_rdata;
    endtask

    initial begin
        logic [7:0] v;
        logic exp_sci;
        repeat (3) @(negedge clk);
        // R1 during and after reset
        chk("R1 sci_n in reset", {7'd0, sci_n}, 8'h01);
        rst = 0;
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            rd_h(a[1:0], v); chk("R1 host read", v, 8'h00);
            rd_e(a[1:0], v); chk("R1 ec read", v, 8'h00);
        end
        chk("R1 sci_n", {7'd0, sci_n}, 8'h01);
        chk("R1 pulses", {5'd0, ec_slp_req, ec_sts_irq, ec_en_irq}, 8'h00);

        // R2 masks, R8 enable pulse
        host_wr(2'd1, 8'hFF);
        chk("R8 en pulse", {6'd0, ec_sts_irq, ec_en_irq}, 8'h01);
        @(negedge clk);
        chk("R8 en pulse one cycle", {7'd0, ec_en_irq}, 8'h00);
        host_wr(2'd3, 8'hFF);
        host_wr(2'd2, 8'hFF);
        chk("R9 slp pulse", {7'd0, ec_slp_req}, 8'h01);
        ec_wr(2'd0, 8'hFF);
        rd_h(2'd0, v); chk("R2 status mask", v, 8'h8F);
        rd_h(2'd1, v); chk("R2 enable mask", v, 8'h07);
        rd_h(2'd2, v); chk("R2 ctl mask R9 slpen reads 0", v, 8'h1C);
        rd_e(2'd3, v); chk("R2 octl mask", v, 8'h02);
        chk("R7 sci active", {7'd0, sci_n}, 8'h00);

        // R4 host clear
        host_wr(2'd0, 8'h00);
        chk("R8 sts pulse", {6'd0, ec_sts_irq, ec_en_irq}, 8'h02);
        rd_e(2'd0, v); chk("R4 write 0 keeps", v, 8'h8F);
        host_wr(2'd0, 8'h05);
        rd_e(2'd0, v); chk("R4 write 1 clears", v, 8'h8A);
        host_wr(2'd0, 8'hFF);
        rd_e(2'd0, v); chk("R4 clear all", v, 8'h00);

        // R6 EC cannot write host-owned registers
        ec_wr(2'd1, 8'h00); ec_wr(2'd2, 8'h00); ec_wr(2'd3, 8'h00);
        rd_h(2'd1, v); chk("R6 enable kept", v, 8'h07);
        rd_h(2'd2, v); chk("R6 ctl kept", v, 8'h1C);
        rd_h(2'd3, v); chk("R6 octl kept", v, 8'h02);

        // R5 same-cycle conflict
        both_sts(8'h81, 8'hFF);
        rd_e(2'd0, v); chk("R5 EC set wins", v, 8'h81);
        both_sts(8'h00, 8'h00);
        rd_e(2'd0, v); chk("R5 EC clear", v, 8'h00);

        // R3/R7 sweep
        for (int e = 0; e < 8; e++) begin
            for (int o = 0; o < 2; o++) begin
                host_wr(2'd1, e[7:0]);
                host_wr(2'd3, 8'(o << 1));
                for (int s = 0; s < 256; s++) begin
                    ec_wr(2'd0, s[7:0]);
                    rd_e(2'd0, v); chk("R3 ec load", v, s[7:0] & 8'h8F);
                    exp_sci = !((|(s[2:0] & e[2:0])) || (s[3] && o[0]));
                    chk("R7 sci", {7'd0, sci_n}, {7'd0, exp_sci});
                end
            end
        end

        // R9 sleep type field
        host_wr(2'd2, 8'h14);
        chk("R9 no slp pulse", {7'd0, ec_slp_req}, 8'h00);
        rd_h(2'd2, v); chk("R9 type stored", v, 8'h14);
        host_wr(2'd2, 8'h28);
        chk("R9 slp pulse", {7'd0, ec_slp_req}, 8'h01);
        rd_h(2'd2, v); chk("R9 slpen reads 0", v, 8'h08);

        // R10 quiesce
        ec_wr(2'd0, 8'h00);
        quiesce = 1;
        host_wr(2'd1, 8'h01);
        chk("R10 no en pulse", {7'd0, ec_en_irq}, 8'h00);
        rd_h(2'd1, v); chk("R10 enable written", v, 8'h01);
        host_wr(2'd2, 8'h20);
        chk("R10 no slp pulse", {7'd0, ec_slp_req}, 8'h00);
        ec_wr(2'd0, 8'h01);
        chk("R10 sci computed", {7'd0, sci_n}, 8'h00);
        host_wr(2'd0, 8'h01);
        chk("R10 no sts pulse", {7'd0, ec_sts_irq}, 8'h00);
        chk("R10 sci released", {7'd0, sci_n}, 8'h01);
        quiesce = 0;
        host_wr(2'd1, 8'h00);
        chk("R10 pulse resumes", {7'd0, ec_en_irq}, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule